// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Frame Check

This block turns an asynchronous serial line into parallel bytes. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit, with no parity bit and no flow control. The number of clock cycles per bit comes from two parameters: the system clock rate, which defaults to 100 MHz, and the baud rate. The line first passes through a two-stage synchroniser. A falling edge on the idle line starts a frame. From that edge, the receiver samples the middle of every bit period.

When the stop bit is high at its midpoint, the block loads the assembled byte onto its parallel output and raises a completion strobe for a single clock cycle. This strobe falls just after the middle of the stop bit. A start bit that has gone high again by its midpoint is a framing fault, and so is a stop bit that is low at its midpoint. Either fault sets an error flag that stays set until reset and sends the receiver back to idle. Reception of later frames continues while the flag is set.

Top module: `uart_frame_rx`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `byte_o` is 0x00 and `done_o` and `frame_err_o` are low. The receiver waits in idle with the line taken as high.
- R2: A well-formed frame delivers its eight data bits on `byte_o`. The first data bit after the start bit is bit 0 and the last is bit 7. The start bit is low (0) and the stop bit is high (1).
- R3: A well-formed frame produces exactly one `done_o` pulse, one cycle wide. With DIV = CLK_HZ/BAUD, the pulse appears after the middle of the stop bit and before the stop bit ends. These times are measured from the falling edge of the start bit at the pin.
- R4: `byte_o` changes only in a cycle where `done_o` is high, so it keeps the last good byte between frames.
- R5: If the line is high again by the middle of the start bit, `frame_err_o` is set, no `done_o` pulse follows, and the receiver returns to idle.
- R6: If the stop bit is low at its midpoint, `frame_err_o` is set, no `done_o` pulse follows, and `byte_o` keeps its previous value.
- R7: Once set, `frame_err_o` stays high until reset, and well-formed frames received meanwhile are still delivered. Well-formed frames never set it.
- R8: A frame whose start bit directly follows the previous stop bit, with no idle time between them, is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| serial_i | input | 1 | Asynchronous serial line, idle high |
| byte_o | output | 8 | Last byte received with a valid frame |
| done_o | output | 1 | One-cycle pulse when a byte is delivered |
| frame_err_o | output | 1 | Sticky framing fault flag |

## Verification
The bench builds the block with CLK_HZ = 1,600,000 and BAUD = 100,000, which gives 16 clock cycles per bit and a half period of 8. At that size a frame lasts 160 cycles. Dozens of random bytes with random idle gaps, back-to-back frames, and both kinds of framing fault therefore fit in a short run. Because the divisor is exact, the bench can predict the cycle window in which the completion strobe must appear.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } urx_state_e;

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/urx_bit_timer.sv
module urx_bit_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = load_val_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import urx_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 115_200,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              done_o,
    output logic              frame_err_o
);
    localparam int DIV   = CLK_HZ / BAUD;
    localparam int HALF  = DIV / 2;
    localparam int CW    = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    localparam logic [CW-1:0]    FULL_RELOAD = CW'(DIV - 1);
    localparam logic [CW-1:0]    HALF_RELOAD = CW'(HALF - 1);
    localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(DATA_W - 1);

    typedef struct packed {
        urx_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shift;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              err;
        logic              prev;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic          line_s;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expire;
    logic          fall;

    urx_sync #(.STAGES(2), .RESET_VAL(1'b1)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (serial_i),
        .sync_o  (line_s)
    );

    urx_bit_timer #(.CW(CW)) i_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (tmr_expire)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.prev = line_s;
        tmr_load = 1'b0;
        tmr_val  = FULL_RELOAD;
        fall     = r_q.prev & ~line_s;

        case (r_q.st)
            ST_IDLE: begin
                if (fall) begin
                    r_d.st   = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = HALF_RELOAD;
                end
            end
            ST_START: begin
                if (tmr_expire) begin
                    if (!line_s) begin
                        r_d.st   = ST_DATA;
                        r_d.idx  = '0;
                        tmr_load = 1'b1;
                    end else begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (tmr_expire) begin
                    r_d.shift = {line_s, r_q.shift[DATA_W-1:1]};
                    tmr_load  = 1'b1;
                    if (r_q.idx == LAST_IDX) r_d.st  = ST_STOP;
                    else                     r_d.idx = r_q.idx + 1'b1;
                end
            end
            default: begin
                if (tmr_expire) begin
                    r_d.st = ST_IDLE;
                    if (line_s) begin
                        r_d.data = r_q.shift;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= ST_IDLE;
            r_q.idx   <= '0;
            r_q.shift <= '0;
            r_q.data  <= '0;
            r_q.done  <= 1'b0;
            r_q.err   <= 1'b0;
            r_q.prev  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_o      = r_q.data;
    assign done_o      = r_q.done;
    assign frame_err_o = r_q.err;
endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              line_s,
    input logic              done,
    input logic              err,
    input logic [DATA_W-1:0] data
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !err && data == '0));

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_strobe_needs_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(rst)) |-> $past(line_s));

    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(data)) |-> done);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

bind uart_frame_rx urx_checker #(.DATA_W(DATA_W)) i_urx_checker (
    .clk    (clk),
    .rst    (rst),
    .line_s (line_s),
    .done   (done_o),
    .err    (frame_err_o),
    .data   (byte_o)
);

// File: tb/test_uart_frame_rx.sv
module test_uart_frame_rx;
    localparam int CLK_HZ = 1_600_000;
    localparam int BAUD   = 100_000;
    localparam int DIV    = CLK_HZ / BAUD;

    logic       clk = 1'b0;
    logic       rst;
    logic       ser;
    logic [7:0] byte_o;
    logic       done_o;
    logic       frame_err_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 0;

    logic [7:0] got_q[$];
    int         when_q[$];

    always #2 clk = ~clk;

    uart_frame_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(8)) i_uart_frame_rx (
        .clk         (clk),
        .rst         (rst),
        .serial_i    (ser),
        .byte_o      (byte_o),
        .done_o      (done_o),
        .frame_err_o (frame_err_o)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (done_o) begin
            got_q.push_back(byte_o);
            when_q.push_back(cyc);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit in_window(input int rel);
        return (rel > (DIV * 19) / 2) && (rel <= DIV * 10);
    endfunction

    task automatic wait_bits(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // drives one frame; returns cycle count at the start edge
    task automatic drive_frame(input logic [7:0] b, input bit stop_level, output int t0);
        @(posedge clk); #1;
        ser = 1'b0;
        t0 = cyc;
        wait_bits(DIV);
        for (int i = 0; i < 8; i++) begin
            ser = b[i];
            wait_bits(DIV);
        end
        ser = stop_level;
        wait_bits(DIV);
        ser = 1'b1;
    endtask

    task automatic good_frame(input logic [7:0] b, input int gap, input string req);
        int n0, t0;
        n0 = got_q.size();
        drive_frame(b, 1'b1, t0);
        wait_bits(gap);
        check(got_q.size() == n0 + 1, "R3 one strobe per frame", got_q.size() - n0, 1);
        if (got_q.size() == n0 + 1) begin
            check(got_q[n0] == b, req, got_q[n0], b);
            check(in_window(when_q[n0] - t0), "R3 strobe timing", when_q[n0] - t0, DIV * 10);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ser = 1'b1;
        wait_bits(4);
        rst = 1'b0;
        wait_bits(1);
    endtask

    initial begin
        int n0, t0;
        logic [7:0] hold;
        logic [7:0] seq[4];
        void'($urandom(32'd12345));
        rst = 1'b1;
        ser = 1'b1;
        wait_bits(3);
        check(byte_o == 8'h00 && !done_o && !frame_err_o, "R1 during reset", {byte_o, done_o, frame_err_o}, 0);
        rst = 1'b0;
        wait_bits(1);
        check(byte_o == 8'h00 && !done_o && !frame_err_o, "R1 after release", {byte_o, done_o, frame_err_o}, 0);

        // directed patterns, R2 LSB-first
        good_frame(8'h00, 4, "R2 byte 00");
        good_frame(8'hFF, 4, "R2 byte FF");
        good_frame(8'hA5, 4, "R2 byte A5");
        good_frame(8'h01, 4, "R2 byte 01");
        good_frame(8'h80, 4, "R2 byte 80");

        // R4: output held across idle
        wait_bits(3 * DIV);
        check(byte_o == 8'h80, "R4 byte held", byte_o, 8'h80);

        // R8: back-to-back frames
        n0 = got_q.size();
        for (int i = 0; i < 4; i++) seq[i] = 8'($urandom);
        for (int i = 0; i < 4; i++) drive_frame(seq[i], 1'b1, t0);
        wait_bits(4);
        check(got_q.size() == n0 + 4, "R8 back-to-back count", got_q.size() - n0, 4);
        for (int i = 0; i < 4; i++)
            if (got_q.size() > n0 + i)
                check(got_q[n0 + i] == seq[i], "R8 back-to-back byte", got_q[n0 + i], seq[i]);

        // random bytes with random gaps
        for (int i = 0; i < 30; i++)
            good_frame(8'($urandom), int'($urandom_range(0, 40)), "R2 random byte");
        check(!frame_err_o, "R7 no error from good frames", frame_err_o, 0);

        // R5: glitch start bit
        hold = byte_o;
        n0 = got_q.size();
        @(posedge clk); #1;
        ser = 1'b0;
        wait_bits(3);
        ser = 1'b1;
        wait_bits(2 * DIV);
        check(got_q.size() == n0, "R5 no strobe on false start", got_q.size() - n0, 0);
        check(frame_err_o, "R5 error on false start", frame_err_o, 1);

        // R7: still receives, flag sticky
        good_frame(8'h3C, 4, "R7 byte after error");
        check(frame_err_o, "R7 error sticky", frame_err_o, 1);

        // R1: reset clears error
        do_reset();
        check(!frame_err_o && byte_o == 8'h00, "R1 reset clears", {frame_err_o, byte_o}, 0);

        // R6: bad stop bit
        good_frame(8'h5A, 4, "R2 byte before bad stop");
        n0 = got_q.size();
        drive_frame(8'hC3, 1'b0, t0);
        wait_bits(2 * DIV);
        check(got_q.size() == n0, "R6 no strobe on bad stop", got_q.size() - n0, 0);
        check(frame_err_o, "R6 error on bad stop", frame_err_o, 1);
        check(byte_o == 8'h5A, "R6 byte unchanged", byte_o, 8'h5A);
        good_frame(8'h96, 4, "R7 byte after stop error");
        check(frame_err_o, "R7 error sticky after frame", frame_err_o, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule